// File: doc/BRIEF.md
# Read-Triggered Converter Host Port

This block sits between a small byte-wide host bus (4-bit address, separate read and write strobes, 8-bit data) and a 12-bit multiplexed analog-to-digital converter. The host programs the multiplexer channel and the gain range through a control register. It polls an end-of-conversion flag in a status byte that shares the control register's address. It collects the result as a low byte and a high byte. Reading the low byte has a side effect: it starts the next conversion. There is no separate start register. A typical polling loop therefore reads the low byte once to start a conversion, waits for the flag, reads the high byte and then reads the low byte, which also starts the next conversion.

The converter is modelled as three parts: a one-cycle start pulse sent out, a busy period of `CONV_CYCLES` clocks counted inside the block, and a 12-bit result input captured when that period ends. Two board straps are sampled whenever the control register is written. The first, differential mode, limits the channel to 8 inputs. The second, unipolar mode, is reported beside the 2-bit gain code, which picks full scale of 5, 2, 1 or 0.5 volts. The pacer enable and pacer interrupt enable bits are held and driven out, but nothing in the block acts on them.

Top module: `adc_host_port`

## Requirements
- R1: After synchronous reset the channel, range, pacer enable and pacer interrupt enable outputs are zero, the end-of-conversion flag is 1 and the stored result is 0x000.
- R2: A write to address 0x0 updates the outputs on the same clock edge: channel from data bits 3:0, gain code from bits 5:4, pacer enable from bit 6 and pacer interrupt enable from bit 7. Writes to any other address leave these outputs unchanged.
- R3: When the differential strap is 1 at the time of the control write, bit 3 of the channel output is forced to 0.
- R4: The range output is {unipolar strap, gain code}, with the strap sampled at the control write.
- R5: A read of address 0x0 returns status, registered one cycle after the strobe: bit 7 is the timer-2 input, bit 6 is the pacer input, bit 5 is end-of-conversion and bits 4:0 are the five digital inputs.
- R6: A read of address 0x8 returns result bits 7:0. When no conversion is running, the same read raises `conv_start` for exactly one cycle and clears end-of-conversion, both on the read edge.
- R7: End-of-conversion sets `CONV_CYCLES` clocks after the start edge. On that edge `conv_result` is captured as the new result.
- R8: A read of address 0x9 returns result bits 11:8 in data bits 3:0, with data bits 7:4 at zero.
- R9: A read of address 0x8 while a conversion is running returns the previous result's low byte. It produces no start pulse and does not move the completion time.
- R10: Writing the control register never starts a conversion and never changes end-of-conversion.
- R11: A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Host register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| dig_in | input | 5 | General-purpose input lines shown in status |
| pacer_in | input | 1 | Pacer output level shown in status |
| timer2_in | input | 1 | Timer-2 output level shown in status |
| diff_strap | input | 1 | 1 = differential inputs (8 channels) |
| unipolar_strap | input | 1 | 1 = unipolar ranges |
| conv_result | input | 12 | Converter output code, captured at end of busy |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| mux_chan | output | 4 | Analog multiplexer channel select |
| range_sel | output | 3 | {unipolar, gain code} to the gain stage |
| pacer_en | output | 1 | Held pacer enable bit |
| pacer_irq_en | output | 1 | Held pacer interrupt enable bit |

## Verification
The conversion path is run three ways. The first is a clean trigger followed by back-to-back status polls. This pins the exact cycle on which the flag returns and separates an off-by-one in the busy count from a correct one. The second repeats the poll with an extra low-byte read in the middle of the busy period. This tells an ignored trigger apart from one that restarts the count or emits a second pulse, and it also checks that the old low byte is returned. Control writes are tried with alternating bit patterns, with each strap set and cleared, and with writes to a non-control address. Together these expose swapped fields, a missing strap mask and writes that leak into a conversion start.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  // Register offsets on the host bus
  localparam int OFS_CTRL_STAT = 'h0;
  localparam int OFS_RES_LO    = 'h8;
  localparam int OFS_RES_HI    = 'h9;

  // Status byte bit positions above the digital input field
  localparam int ST_EOC   = 5;
  localparam int ST_PACER = 6;
  localparam int ST_TMR2  = 7;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_port_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CHAN_W = 4,
  parameter int GAIN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              diff_strap,
  input  logic              unipolar_strap,
  output logic [CHAN_W-1:0] mux_chan,
  output logic [GAIN_W:0]   range_sel,
  output logic              pacer_en,
  output logic              pacer_irq_en
);
  localparam int GAIN_LO  = CHAN_W;
  localparam int GAIN_HI  = CHAN_W + GAIN_W - 1;
  localparam int PACER_B  = DATA_W - 2;
  localparam int IRQ_B    = DATA_W - 1;
  localparam logic [CHAN_W-1:0] DIFF_MASK = {1'b0, {(CHAN_W-1){1'b1}}};

  logic              ctrl_hit;
  logic [CHAN_W-1:0] chan_next;

  assign ctrl_hit  = wr_en && (addr == ADDR_W'(OFS_CTRL_STAT));
  assign chan_next = diff_strap ? (wdata[CHAN_W-1:0] & DIFF_MASK)
                                : wdata[CHAN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_chan     <= '0;
      range_sel    <= '0;
      pacer_en     <= 1'b0;
      pacer_irq_en <= 1'b0;
    end else if (ctrl_hit) begin
      mux_chan     <= chan_next;
      range_sel    <= {unipolar_strap, wdata[GAIN_HI:GAIN_LO]};
      pacer_en     <= wdata[PACER_B];
      pacer_irq_en <= wdata[IRQ_B];
    end
  end

  // R2: no control write means the analog-side settings hold
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_hit |=> ($stable(mux_chan) && $stable(range_sel)
                   && $stable(pacer_en) && $stable(pacer_irq_en)));

  // R3: differential strap keeps the channel inside the lower half
  p_diff_chan_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && diff_strap) |=> !mux_chan[CHAN_W-1]);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_port_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int CONV_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_req,
  input  logic [RES_W-1:0] conv_result,
  output logic             conv_start,
  output logic             eoc,
  output logic [RES_W-1:0] result
);
  localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      cnt        <= '0;
      conv_start <= 1'b0;
      eoc        <= 1'b1;
      result     <= '0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (trig_req) begin
            state      <= SEQ_BUSY;
            cnt        <= '0;
            conv_start <= 1'b1;
            eoc        <= 1'b0;
          end
        end
        SEQ_BUSY: begin
          if (cnt == CNT_LAST) begin
            state  <= SEQ_IDLE;
            eoc    <= 1'b1;
            result <= conv_result;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R6: a start pulse always comes with a cleared flag
  p_start_clears_eoc_r6: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !eoc);

  // R9: a start is never followed by a second start on the next cycle
  p_single_start_r9: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R7: the flag rises only together with a fresh capture
  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc) |-> (result == $past(conv_result)));

  // R9: before the last busy count the flag stays low
  p_busy_low_r9: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_BUSY && cnt != CNT_LAST) |=> !eoc);
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
  import adc_port_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int RES_W  = 12,
  parameter int DIN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIN_W-1:0]  dig_in,
  input  logic              pacer_in,
  input  logic              timer2_in,
  input  logic              eoc,
  input  logic [RES_W-1:0]  result,
  output logic              trig_req,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = RES_W - DATA_W;

  logic [DATA_W-1:0] status_b;
  logic [DATA_W-1:0] lo_b;
  logic [DATA_W-1:0] hi_b;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    status_b                 = '0;
    status_b[DIN_W-1:0]      = dig_in;
    status_b[ST_EOC]         = eoc;
    status_b[ST_PACER]       = pacer_in;
    status_b[ST_TMR2]        = timer2_in;
  end

  assign lo_b = result[DATA_W-1:0];
  assign hi_b = {{(DATA_W-HI_W){1'b0}}, result[RES_W-1:DATA_W]};

  always_comb begin
    if (addr == ADDR_W'(OFS_CTRL_STAT))   rd_next = status_b;
    else if (addr == ADDR_W'(OFS_RES_LO)) rd_next = lo_b;
    else if (addr == ADDR_W'(OFS_RES_HI)) rd_next = hi_b;
    else                                  rd_next = '0;
  end

  assign trig_req = rd_en && (addr == ADDR_W'(OFS_RES_LO));

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  // R8: upper bits of the high byte read as zero
  p_hi_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFS_RES_HI)) |=> (rdata[DATA_W-1:HI_W] == '0));

  // R5: the status flag read back is the flag of the read cycle
  p_status_eoc_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFS_CTRL_STAT)) |=> (rdata[ST_EOC] == $past(eoc)));
endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
  import adc_port_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int RES_W       = 12,
  parameter int CHAN_W      = 4,
  parameter int GAIN_W      = 2,
  parameter int DIN_W       = 5,
  parameter int CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DIN_W-1:0]  dig_in,
  input  logic              pacer_in,
  input  logic              timer2_in,
  input  logic              diff_strap,
  input  logic              unipolar_strap,
  input  logic [RES_W-1:0]  conv_result,
  output logic              conv_start,
  output logic [CHAN_W-1:0] mux_chan,
  output logic [GAIN_W:0]   range_sel,
  output logic              pacer_en,
  output logic              pacer_irq_en
);
  logic             trig_req;
  logic             eoc;
  logic [RES_W-1:0] result;

  adc_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W), .GAIN_W(GAIN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .diff_strap(diff_strap), .unipolar_strap(unipolar_strap),
    .mux_chan(mux_chan), .range_sel(range_sel),
    .pacer_en(pacer_en), .pacer_irq_en(pacer_irq_en)
  );

  adc_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W), .DIN_W(DIN_W)
  ) u_rmux (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .addr(bus_addr),
    .dig_in(dig_in), .pacer_in(pacer_in), .timer2_in(timer2_in),
    .eoc(eoc), .result(result), .trig_req(trig_req), .rdata(bus_rdata)
  );

  adc_conv_seq #(
    .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .trig_req(trig_req), .conv_result(conv_result),
    .conv_start(conv_start), .eoc(eoc), .result(result)
  );

  // R10: a control write alone never produces a start pulse
  p_wr_no_start_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd) |=> !conv_start);
endmodule

// File: tb/adc_host_port_bench.sv
module adc_host_port_bench;
  localparam int CONV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [4:0]  dig_in = 5'h15;
  logic        pacer_in = 1'b1;
  logic        timer2_in = 1'b0;
  logic        diff_strap = 1'b0;
  logic        unipolar_strap = 1'b0;
  logic [11:0] conv_result = 12'hABC;
  logic        conv_start;
  logic [3:0]  mux_chan;
  logic [2:0]  range_sel;
  logic        pacer_en;
  logic        pacer_irq_en;

  adc_host_port #(.CONV_CYCLES(CONV)) u_adc_host_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dig_in(dig_in),
    .pacer_in(pacer_in), .timer2_in(timer2_in), .diff_strap(diff_strap),
    .unipolar_strap(unipolar_strap), .conv_result(conv_result),
    .conv_start(conv_start), .mux_chan(mux_chan), .range_sel(range_sel),
    .pacer_en(pacer_en), .pacer_irq_en(pacer_irq_en)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int starts = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Scoreboard monitor: pops one expectation per completed read
  always @(posedge clk) begin
    rd_seen <= rst ? 1'b0 : bus_rd;
    if (!rst && conv_start) starts = starts + 1;
  end

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {24'h0, bus_rdata}, {24'h0, e});
    end
  end

  function automatic logic [7:0] stat(input logic e);
    return {timer2_in, pacer_in, e, dig_in};
  endfunction

  // Driver tasks: one bus access per cycle, pushing expectations
  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    bus_rd   = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values at the ports
    chk("R1 mux_chan", {28'h0, mux_chan}, 0);
    chk("R1 range_sel", {29'h0, range_sel}, 0);
    chk("R1 pacer_en", {31'h0, pacer_en}, 0);
    chk("R1 pacer_irq_en", {31'h0, pacer_irq_en}, 0);
    rd(4'h0, stat(1'b1), "R1 R5 status after reset");
    rd(4'h9, 8'h00, "R1 R8 high byte after reset");
    rd(4'h8, 8'h00, "R1 R6 low byte after reset");
    chk("R6 start pulse on trigger read", {31'h0, conv_start}, 1);

    // R7: flag returns exactly CONV clocks after the start edge
    for (int i = 1; i <= CONV + 1; i++)
      rd(4'h0, stat(i >= CONV + 1), "R7 eoc timing");
    chk("R6 single start pulse", starts, 1);
    rd(4'h9, 8'h0A, "R8 high nibble");

    // R9: a trigger read while busy is ignored
    conv_result = 12'h5E7;
    rd(4'h8, 8'hBC, "R6 low byte then trigger");
    for (int i = 1; i <= CONV + 1; i++) begin
      if (i == 2) rd(4'h8, 8'hBC, "R9 busy read returns old low byte");
      else        rd(4'h0, stat(i >= CONV + 1), "R9 completion unchanged");
    end
    chk("R9 no extra start", starts, 2);
    rd(4'h9, 8'h05, "R8 high byte second result");
    rd(4'h8, 8'hE7, "R6 low byte second result");
    repeat (CONV + 2) @(negedge clk);

    // R2: field placement
    wr(4'h0, 8'hA7);
    chk("R2 chan", {28'h0, mux_chan}, 4'h7);
    chk("R2 range", {29'h0, range_sel}, 3'b010);
    chk("R2 pacer", {31'h0, pacer_en}, 0);
    chk("R2 irq", {31'h0, pacer_irq_en}, 1);
    wr(4'h0, 8'h5C);
    chk("R2 chan alt", {28'h0, mux_chan}, 4'hC);
    chk("R2 range alt", {29'h0, range_sel}, 3'b001);
    chk("R2 pacer alt", {31'h0, pacer_en}, 1);
    chk("R2 irq alt", {31'h0, pacer_irq_en}, 0);
    wr(4'h4, 8'hFF);
    chk("R2 other address ignored", {24'h0, mux_chan, range_sel[1:0], pacer_en, pacer_irq_en},
        {24'h0, 4'hC, 2'b01, 1'b1, 1'b0});

    // R10: control writes start nothing
    chk("R10 no start from writes", starts, 3);
    rd(4'h0, stat(1'b1), "R10 eoc still set");

    // R3: differential strap masks channel bit 3
    diff_strap = 1'b1;
    wr(4'h0, 8'h0F);
    chk("R3 diff masks chan", {28'h0, mux_chan}, 4'h7);
    diff_strap = 1'b0;
    wr(4'h0, 8'h0F);
    chk("R3 single-ended full chan", {28'h0, mux_chan}, 4'hF);

    // R4: polarity strap beside gain
    unipolar_strap = 1'b1;
    wr(4'h0, 8'h30);
    chk("R4 unipolar range", {29'h0, range_sel}, 3'b111);
    unipolar_strap = 1'b0;

    // R5: another status pattern
    dig_in = 5'h0A; pacer_in = 1'b0; timer2_in = 1'b1;
    rd(4'h0, 8'hAA, "R5 status pattern");

    // R11: unmapped addresses
    rd(4'h3, 8'h00, "R11 unmapped 0x3");
    rd(4'hF, 8'h00, "R11 unmapped 0xF");

    repeat (2) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule